// File: doc/BRIEF.md
# Atomic Semaphore Read-Modify-Write Unit

This block carries out one atomic semaphore operation at a time against a small single-port word memory that it owns. The three operations are swap, compare-and-swap and fetch-and-add. Each operation works on a 1, 2, 4 or 8 byte lane inside a 64-bit word. A request carries an opcode, a byte address, a size code, a memory attribute, a legacy-mode flag and a lock-control bit. Before the block touches memory, it classifies the request. If the request is not allowed, the block returns a fault code and performs no memory access.

A second, plain word port lets another agent read and write the same memory. That port is shut out for the whole span between the atomic read and the atomic write-back, so the read-modify-write cannot be split. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. The result appears with a one-cycle `done` pulse, together with the old lane value and the fault code.

Top module: `sema_rmw_unit`

## Requirements
- R1: The side port is granted (`ext_gnt`) only in two cases: while the unit is idle with no atomic request pending, or in the cycle `done` is high. An atomic request presented in the same cycle as a side request wins, and no side grant occurs between the atomic read and its write-back.
- R2: Swap (opcode 2'b00) writes the operand's low lane into the addressed lane and returns the previous lane value, zero-extended, on `old_value`.
- R3: Compare-and-swap (opcode 2'b01) writes the operand lane only when the old lane equals the compare operand's low lane. In both cases it returns the old lane.
- R4: Fetch-and-add (opcode 2'b10) stores old lane plus operand, truncated to the lane width so that it wraps, and returns the old lane.
- R5: Size code 0,1,2,3 selects 1,2,4,8 bytes. The lane starts at bit 8*addr[2:0] of word addr[ADDR_W-1:3]. Bytes outside the lane are left unchanged.
- R6: Attribute code 2'b00 is write-back cacheable, 2'b01 uncacheable, 2'b10 exported uncacheable and 2'b11 reserved. Any non-cacheable attribute gives fault code 1, with one exception: fetch-and-add to attribute 2'b10 runs normally when EXPORT_FADD=1. Opcode 2'b11 also gives fault code 1.
- R7: With EXPORT_FADD=0, fetch-and-add to attribute 2'b10 gives fault code 1.
- R8: An address that is not a multiple of the access size gives fault code 2. When both the attribute check and the alignment check fail, fault code 1 wins.
- R9: A legacy request with lock-control 1 that is non-cacheable or misaligned gives fault code 3, and never codes 1 or 2. With lock-control 0, a legacy request follows R6 and R8. An aligned legacy request to write-back memory runs normally.
- R10: A faulting request makes no memory access and returns `old_value` 0. Its `done` is high in the cycle after the second clock edge following acceptance. A successful request reports fault code 0.
- R11: A successful request raises `done` after the fifth edge following acceptance, once the write-back has happened. `done` lasts one cycle. `req_ready` is low from acceptance through the `done` cycle and is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Atomic request present |
| req_ready | output | 1 | Unit can accept an atomic request |
| req_op | input | 2 | Opcode: 0 swap, 1 compare-and-swap, 2 fetch-and-add, 3 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code (1 << code bytes) |
| req_attr | input | 2 | Memory attribute code |
| req_legacy | input | 1 | Request comes from legacy-mode code |
| req_lock_ctl | input | 1 | Lock-control configuration bit |
| req_operand | input | 64 | New value or addend |
| req_compare | input | 64 | Compare value for compare-and-swap |
| done | output | 1 | One-cycle completion pulse |
| old_value | output | 64 | Previous lane value, zero-extended |
| fault | output | 2 | 0 none, 1 unsupported, 2 unaligned, 3 lock intercept |
| ext_req | input | 1 | Side port access request |
| ext_we | input | 1 | Side port write enable |
| ext_idx | input | IDX_W | Side port word index |
| ext_wdata | input | 64 | Side port write data |
| ext_gnt | output | 1 | Side port access granted this cycle |
| ext_rdata | output | 64 | Side port read data, valid the cycle after a read grant |

## Verification
The assertions assume that the request fields stay meaningful only in the accepting cycle; the unit captures them there. They also assume that the side port is used as a request-per-cycle port whose grant is sampled in the same cycle. The bench drives every input half a period away from the active edge. It drops `req_valid` right after acceptance. It raises the side request during an atomic operation only to observe that no grant appears, and it issues its own side reads and writes only while the unit is idle. All expected lane values are worked out by hand from the operation rules and confirmed by reading the memory back through the side port.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    OP_SWAP  = 2'b00,
    OP_CAS   = 2'b01,
    OP_FADD  = 2'b10,
    OP_RSVD  = 2'b11
  } sema_op_e;

  typedef enum logic [1:0] {
    ATTR_WB   = 2'b00,
    ATTR_UC   = 2'b01,
    ATTR_UCE  = 2'b10,
    ATTR_RSVD = 2'b11
  } mem_attr_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_UNSUP   = 2'b01,
    FLT_UNALIGN = 2'b10,
    FLT_LOCK    = 2'b11
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHECK  = 3'd1,
    ST_READ   = 3'd2,
    ST_MODIFY = 3'd3,
    ST_WRITE  = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;

  typedef struct packed {
    sema_op_e  op;
    logic [1:0] size;
    mem_attr_e attr;
    logic      legacy;
    logic      lock_ctl;
  } req_ctl_t;
endpackage

// File: rtl/sema_rst_sync.sv
module sema_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sema_fault_check.sv
module sema_fault_check
  import sema_pkg::*;
#(
  parameter bit EXPORT_FADD = 1'b1
) (
  input  req_ctl_t   ctl,
  input  logic [2:0] byte_off,
  output fault_e     fault_code
);
  logic misaligned;
  logic attr_ok;
  logic op_ok;
  logic intercept;

  always_comb begin
    unique case (ctl.size)
      2'd0:    misaligned = 1'b0;
      2'd1:    misaligned = byte_off[0];
      2'd2:    misaligned = |byte_off[1:0];
      default: misaligned = |byte_off;
    endcase
  end

  always_comb begin
    op_ok     = (ctl.op != OP_RSVD);
    attr_ok   = (ctl.attr == ATTR_WB) ||
                (EXPORT_FADD && (ctl.attr == ATTR_UCE) && (ctl.op == OP_FADD));
    intercept = ctl.legacy && ctl.lock_ctl &&
                ((ctl.attr != ATTR_WB) || misaligned);
  end

  always_comb begin
    if (intercept)               fault_code = FLT_LOCK;
    else if (!attr_ok || !op_ok) fault_code = FLT_UNSUP;
    else if (misaligned)         fault_code = FLT_UNALIGN;
    else                         fault_code = FLT_NONE;
  end
endmodule

// File: rtl/sema_modify.sv
module sema_modify
  import sema_pkg::*;
(
  input  logic [DATA_W-1:0] word_in,
  input  logic [2:0]        byte_off,
  input  logic [1:0]        size,
  input  sema_op_e          op,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] compare,
  output logic [DATA_W-1:0] old_lane,
  output logic [DATA_W-1:0] word_out
);
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] new_lane;
  logic [5:0]        bit_sh;

  always_comb begin
    unique case (size)
      2'd0:    lane_mask = 64'h0000_0000_0000_00FF;
      2'd1:    lane_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    lane_mask = 64'h0000_0000_FFFF_FFFF;
      default: lane_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  end

  always_comb begin
    bit_sh   = {byte_off, 3'b000};
    old_lane = (word_in >> bit_sh) & lane_mask;
    unique case (op)
      OP_SWAP: new_lane = operand;
      OP_CAS:  new_lane = (old_lane == (compare & lane_mask)) ? operand : old_lane;
      OP_FADD: new_lane = old_lane + operand;
      default: new_lane = old_lane;
    endcase
    word_out = (word_in & ~(lane_mask << bit_sh)) |
               ((new_lane & lane_mask) << bit_sh);
  end
endmodule

// File: rtl/sema_mem.sv
module sema_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[idx] <= wdata;
      else    rdata      <= store[idx];
    end
  end
endmodule

// File: rtl/sema_rmw_unit.sv
module sema_rmw_unit
  import sema_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter bit EXPORT_FADD = 1'b1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_attr,
  input  logic              req_legacy,
  input  logic              req_lock_ctl,
  input  logic [63:0]       req_operand,
  input  logic [63:0]       req_compare,
  output logic              done,
  output logic [63:0]       old_value,
  output logic [1:0]        fault,
  input  logic              ext_req,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [63:0]       ext_wdata,
  output logic              ext_gnt,
  output logic [63:0]       ext_rdata
);
  logic rst_sync_n;

  sema_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  seq_state_e        state_q, state_d;
  req_ctl_t          ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] operand_q, compare_q;
  fault_e            fault_q, fault_d;
  logic [DATA_W-1:0] old_q, old_d;
  logic [DATA_W-1:0] new_word_q;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] lane_old, word_new;

  logic accept, ld_fault, ld_old, ld_new;
  logic atomic_rd, atomic_wr;
  logic mem_en, mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] mem_wdata;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sema_fault_check #(.EXPORT_FADD(EXPORT_FADD)) u_fault_check (
    .ctl        (ctl_q),
    .byte_off   (addr_q[2:0]),
    .fault_code (fault_d)
  );

  sema_modify u_modify (
    .word_in  (mem_rdata),
    .byte_off (addr_q[2:0]),
    .size     (ctl_q.size),
    .op       (ctl_q.op),
    .operand  (operand_q),
    .compare  (compare_q),
    .old_lane (lane_old),
    .word_out (word_new)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_CHECK;
      ST_CHECK:  state_d = (fault_d != FLT_NONE) ? ST_DONE : ST_READ;
      ST_READ:   state_d = ST_MODIFY;
      ST_MODIFY: state_d = ST_WRITE;
      ST_WRITE:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // clock enables and data selects
  always_comb begin
    ld_fault = (state_q == ST_CHECK);
    ld_old   = (state_q == ST_CHECK) || (state_q == ST_MODIFY);
    ld_new   = (state_q == ST_MODIFY);
    old_d    = (state_q == ST_MODIFY) ? lane_old : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q     <= '0;
      addr_q    <= '0;
      operand_q <= '0;
      compare_q <= '0;
    end else if (accept) begin
      ctl_q     <= '{op: sema_op_e'(req_op), size: req_size,
                     attr: mem_attr_e'(req_attr), legacy: req_legacy,
                     lock_ctl: req_lock_ctl};
      addr_q    <= req_addr;
      operand_q <= req_operand;
      compare_q <= req_compare;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   fault_q <= FLT_NONE;
    else if (ld_fault) fault_q <= fault_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) old_q <= '0;
    else if (ld_old) old_q <= old_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) new_word_q <= '0;
    else if (ld_new) new_word_q <= word_new;
  end

  // memory port arbitration: atomic sequence owns the port from READ to WRITE
  always_comb begin
    atomic_rd = (state_q == ST_READ);
    atomic_wr = (state_q == ST_WRITE);
    ext_gnt   = ext_req && (((state_q == ST_IDLE) && !req_valid) ||
                            (state_q == ST_DONE));
    mem_en    = atomic_rd || atomic_wr || ext_gnt;
    mem_we    = atomic_wr || (ext_gnt && ext_we);
    mem_idx   = (atomic_rd || atomic_wr) ? addr_q[ADDR_W-1:3] : ext_idx;
    mem_wdata = atomic_wr ? new_word_q : ext_wdata;
  end

  sema_mem #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_mem (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .idx   (mem_idx),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign done      = (state_q == ST_DONE);
  assign old_value = old_q;
  assign fault     = fault_q;
  assign ext_rdata = mem_rdata;
endmodule

// File: rtl/sema_rmw_checker.sv
module sema_rmw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic [1:0] fault,
  input logic       ext_gnt,
  input logic       atomic_wr,
  input logic [2:0] state
);
  logic wrote_q;
  logic in_rmw;

  assign in_rmw = (state == 3'd2) || (state == 3'd3) || (state == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wrote_q <= 1'b0;
    else if (req_valid && req_ready) wrote_q <= 1'b0;
    else if (atomic_wr)              wrote_q <= 1'b1;
  end

  // R1: side port shut out between atomic read and write-back
  p_no_side_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_rmw |-> !ext_gnt);

  // R11: acceptance drops ready, done is a single pulse
  p_ready_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: successful completion only after the write-back
  p_done_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'd0) |-> wrote_q);

  // R10: a fault never writes memory and leaves straight from CHECK
  p_fault_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> !wrote_q);

  p_fault_from_check_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && fault != 2'd0) |-> ($past(state) == 3'd1));
endmodule

bind sema_rmw_unit sema_rmw_checker u_sema_rmw_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .fault     (fault),
  .ext_gnt   (ext_gnt),
  .atomic_wr (atomic_wr),
  .state     (state_q)
);

// File: tb/sema_rmw_unit_bench.sv
module sema_rmw_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ADDR_W = IDX_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_valid_b = 1'b0;
  logic [1:0] req_op = '0, req_size = '0, req_attr = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_legacy = 1'b0, req_lock_ctl = 1'b0;
  logic [63:0] req_operand = '0, req_compare = '0;
  logic ext_req = 1'b0, ext_we = 1'b0;
  logic [IDX_W-1:0] ext_idx = '0;
  logic [63:0] ext_wdata = '0;

  logic req_ready, done, ext_gnt;
  logic [63:0] old_value, ext_rdata;
  logic [1:0] fault;
  logic ready_b, done_b, gnt_b;
  logic [63:0] old_b, rdata_b;
  logic [1:0] fault_b;

  int n_cmp = 0;
  int n_err = 0;
  logic [63:0] r_old;
  logic [1:0]  r_fault;
  int          r_lat;
  logic        r_ready_at_done, r_ready_after, r_probe_bad, r_gnt_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  sema_rmw_unit #(.DEPTH(DEPTH), .EXPORT_FADD(1'b1)) u_sema_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .req_attr(req_attr), .req_legacy(req_legacy), .req_lock_ctl(req_lock_ctl),
    .req_operand(req_operand), .req_compare(req_compare), .done(done),
    .old_value(old_value), .fault(fault), .ext_req(ext_req), .ext_we(ext_we),
    .ext_idx(ext_idx), .ext_wdata(ext_wdata), .ext_gnt(ext_gnt),
    .ext_rdata(ext_rdata)
  );

  sema_rmw_unit #(.DEPTH(DEPTH), .EXPORT_FADD(1'b0)) u_sema_rmw_unit_noexp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid_b), .req_ready(ready_b),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .req_attr(req_attr), .req_legacy(req_legacy), .req_lock_ctl(req_lock_ctl),
    .req_operand(req_operand), .req_compare(req_compare), .done(done_b),
    .old_value(old_b), .fault(fault_b), .ext_req(1'b0), .ext_we(1'b0),
    .ext_idx('0), .ext_wdata('0), .ext_gnt(gnt_b), .ext_rdata(rdata_b)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic side_write(input int idx, input logic [63:0] d);
    @(negedge clk);
    ext_req = 1'b1; ext_we = 1'b1; ext_idx = IDX_W'(idx); ext_wdata = d;
    @(negedge clk);
    ext_req = 1'b0; ext_we = 1'b0;
  endtask

  task automatic side_read(input int idx, output logic [63:0] d);
    @(negedge clk);
    ext_req = 1'b1; ext_we = 1'b0; ext_idx = IDX_W'(idx);
    @(negedge clk);
    ext_req = 1'b0;
    d = ext_rdata;
  endtask

  task automatic do_op(input logic [1:0] op, input int addr, input logic [1:0] sz,
                       input logic [1:0] at, input logic lg, input logic lk,
                       input logic [63:0] opd, input logic [63:0] cmpv, input bit probe);
    @(negedge clk);
    req_op = op; req_addr = ADDR_W'(addr); req_size = sz; req_attr = at;
    req_legacy = lg; req_lock_ctl = lk; req_operand = opd; req_compare = cmpv;
    req_valid = 1'b1;
    if (probe) begin ext_req = 1'b1; ext_we = 1'b0; ext_idx = '0; end
    r_probe_bad = probe && ext_gnt;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    while (!done && r_lat < 20) begin
      if (probe && ext_gnt) r_probe_bad = 1'b1;
      @(negedge clk);
      r_lat++;
    end
    r_old = old_value; r_fault = fault; r_ready_at_done = req_ready;
    r_gnt_done = ext_gnt;
    @(negedge clk);
    ext_req = 1'b0;
    r_ready_after = req_ready;
  endtask

  task automatic expect_ok(input string tag, input logic [63:0] exp_old);
    chk({tag, " old"}, r_old, exp_old);
    chk({tag, " fault R10"}, 64'(r_fault), 64'd0);
    chk({tag, " latency R11"}, 64'(r_lat), 64'd5);
  endtask

  task automatic expect_fault(input string tag, input logic [1:0] code);
    chk({tag, " code"}, 64'(r_fault), 64'(code));
    chk({tag, " old zero R10"}, r_old, 64'd0);
    chk({tag, " latency R10"}, 64'(r_lat), 64'd2);
  endtask

  task automatic t_reset;
    chk("R11 reset ready", 64'(req_ready), 64'd1);
    chk("R11 reset done", 64'(done), 64'd0);
    chk("R10 reset fault", 64'(fault), 64'd0);
  endtask

  task automatic t_swap;
    logic [63:0] w;
    side_write(2, 64'h1122_3344_5566_7788);
    do_op(2'b00, 16, 2'd3, 2'b00, 1'b0, 1'b0, 64'hA5A5_A5A5_A5A5_A5A5, '0, 1'b1);
    expect_ok("R2 swap8", 64'h1122_3344_5566_7788);
    chk("R1 no side grant while busy", 64'(r_probe_bad), 64'd0);
    chk("R1 side grant in done cycle", 64'(r_gnt_done), 64'd1);
    chk("R11 ready low at done", 64'(r_ready_at_done), 64'd0);
    chk("R11 ready back", 64'(r_ready_after), 64'd1);
    side_read(2, w);
    chk("R2 swap8 memory", w, 64'hA5A5_A5A5_A5A5_A5A5);
  endtask

  task automatic t_cas;
    logic [63:0] w;
    side_write(3, 64'hDEAD_BEEF_CAFE_F00D);
    do_op(2'b01, 28, 2'd2, 2'b00, 1'b0, 1'b0, 64'h1234_5678, 64'hDEAD_BEEF, 1'b0);
    expect_ok("R3 cas hit", 64'hDEAD_BEEF);
    side_read(3, w);
    chk("R3 R5 cas hit memory", w, 64'h1234_5678_CAFE_F00D);
    do_op(2'b01, 28, 2'd2, 2'b00, 1'b0, 1'b0, 64'hFFFF_FFFF, 64'h0, 1'b0);
    expect_ok("R3 cas miss", 64'h1234_5678);
    side_read(3, w);
    chk("R3 cas miss memory", w, 64'h1234_5678_CAFE_F00D);
  endtask

  task automatic t_fadd;
    logic [63:0] w;
    side_write(4, 64'hFFFF_0000_0000_0001);
    do_op(2'b10, 38, 2'd1, 2'b00, 1'b0, 1'b0, 64'd1, '0, 1'b0);
    expect_ok("R4 fadd16 wrap", 64'hFFFF);
    side_read(4, w);
    chk("R4 R5 fadd16 memory", w, 64'h0000_0000_0000_0001);
    do_op(2'b10, 32, 2'd0, 2'b00, 1'b0, 1'b0, 64'd5, '0, 1'b0);
    expect_ok("R4 fadd8", 64'h01);
    side_read(4, w);
    chk("R4 R5 fadd8 memory", w, 64'h0000_0000_0000_0006);
  endtask

  task automatic t_attr;
    logic [63:0] w;
    side_write(5, 64'h10);
    do_op(2'b10, 40, 2'd3, 2'b10, 1'b0, 1'b0, 64'h30, '0, 1'b0);
    expect_ok("R6 fadd exported", 64'h10);
    side_read(5, w);
    chk("R6 fadd exported memory", w, 64'h40);
    side_write(6, 64'h77);
    do_op(2'b00, 48, 2'd3, 2'b01, 1'b0, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R6 swap uncacheable", 2'd1);
    do_op(2'b00, 48, 2'd3, 2'b10, 1'b0, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R6 swap exported", 2'd1);
    do_op(2'b11, 48, 2'd3, 2'b00, 1'b0, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R6 reserved opcode", 2'd1);
    do_op(2'b00, 48, 2'd3, 2'b11, 1'b0, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R6 reserved attribute", 2'd1);
  endtask

  task automatic t_align;
    do_op(2'b00, 50, 2'd2, 2'b00, 1'b0, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R8 misaligned word", 2'd2);
    do_op(2'b10, 49, 2'd1, 2'b00, 1'b0, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R8 misaligned half", 2'd2);
    do_op(2'b00, 50, 2'd2, 2'b01, 1'b0, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R8 unsupported over unaligned", 2'd1);
  endtask

  task automatic t_legacy;
    logic [63:0] w;
    do_op(2'b00, 48, 2'd3, 2'b01, 1'b1, 1'b1, 64'h1, '0, 1'b0);
    expect_fault("R9 intercept uncacheable", 2'd3);
    do_op(2'b00, 50, 2'd2, 2'b00, 1'b1, 1'b1, 64'h1, '0, 1'b0);
    expect_fault("R9 intercept misaligned", 2'd3);
    do_op(2'b00, 48, 2'd3, 2'b01, 1'b1, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R9 no lock ctl uncacheable", 2'd1);
    do_op(2'b00, 50, 2'd2, 2'b00, 1'b1, 1'b0, 64'h1, '0, 1'b0);
    expect_fault("R9 no lock ctl misaligned", 2'd2);
    side_read(6, w);
    chk("R10 faults left memory alone", w, 64'h77);
    do_op(2'b00, 40, 2'd2, 2'b00, 1'b1, 1'b1, 64'hAAAA_BBBB, '0, 1'b0);
    expect_ok("R9 legacy aligned cacheable", 64'h40);
    side_read(5, w);
    chk("R9 legacy memory", w, 64'h0000_0000_AAAA_BBBB);
  endtask

  task automatic t_noexport;
    int lat;
    @(negedge clk);
    req_op = 2'b10; req_addr = ADDR_W'(40); req_size = 2'd3; req_attr = 2'b10;
    req_legacy = 1'b0; req_lock_ctl = 1'b0; req_operand = 64'h1;
    req_valid_b = 1'b1;
    @(negedge clk);
    req_valid_b = 1'b0;
    lat = 1;
    while (!done_b && lat < 20) begin @(negedge clk); lat++; end
    chk("R7 fadd exported without support", 64'(fault_b), 64'd1);
    chk("R7 latency", 64'(lat), 64'd2);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_swap();
    t_cas();
    t_fadd();
    t_attr();
    t_align();
    t_legacy();
    t_noexport();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule